// File: doc/BRIEF.md
# Triggered Acquisition Mode Controller

This controller decides which converted scans are kept relative to a trigger event. It watches a one-cycle scan-completion pulse from an upstream scan generator and an external trigger pulse, and it produces a per-scan store enable for the downstream data buffer. It also produces an acquisition-active level, a one-cycle done pulse and a count of the scans kept before the trigger.

Five modes are selectable. In software mode, acquisition starts at once. In post-trigger mode, the controller waits for a trigger. Pre-trigger mode keeps scans until the trigger. Middle mode keeps scans on both sides of the trigger. Delay mode waits a programmed number of clock cycles after the trigger before it keeps scans. Post and delay modes can re-arm themselves after each record, so that every new trigger captures another record. The mode and the counts are read live from the configuration inputs. Software arms a run by raising the enable level and stops it by lowering that level.

Top module: `tacq_ctrl`

## Requirements
- R1: After synchronous reset, acq_active, store_en and acq_done are low, and pre_kept is zero.
- R2: A run starts only on the first clock in which acq_en is high after being low. Lowering acq_en returns the block to idle at the next edge without a done pulse. The mode encoding is 0 software, 1 post, 2 pre, 3 middle and 4 delay. Codes 5 to 7 never start a run.
- R3: Software mode stores the next n_scans scans (n_scans of 0 is taken as 1), then finishes.
- R4: Post mode stores nothing until ext_trig is seen. It then stores the next n_scans scans. A scan in the same cycle as the trigger is not stored.
- R5: Pre mode stores every scan until the trigger and finishes at the trigger edge. pre_kept counts those scans and saturates at m_scans.
- R6: Middle mode behaves like pre mode until the trigger and then stores n_scans further scans. A scan coinciding with the trigger counts as a pre-trigger scan.
- R7: When the trigger comes before m_scans scans have been seen, pre_kept holds the smaller number actually seen. It is cleared at the start of each run.
- R8: Delay mode, after the trigger edge, lets dly_clks+1 clock edges pass without storing. It then stores n_scans scans.
- R9: With retrig_en set in post or delay mode, a finished record returns the block to waiting for a trigger, and acq_active stays high.
- R10: Triggers arriving while scans are being stored after a trigger, or during the delay wait, are ignored.
- R11: acq_done is a single-cycle pulse in the cycle after the edge that ended the record. Without re-trigger, acq_active is low in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acq_en | input | 1 | Acquisition enable level; a rising edge arms a run |
| mode | input | 3 | Trigger mode select |
| retrig_en | input | 1 | Re-arm after each record in post and delay modes |
| m_scans | input | CNT_W | Pre-trigger scan limit |
| n_scans | input | CNT_W | Post-trigger scan count |
| dly_clks | input | DLY_W | Delay after trigger, in clock cycles |
| ext_trig | input | 1 | Trigger pulse |
| scan_done | input | 1 | One pulse per completed scan |
| acq_active | output | 1 | A run is in progress |
| store_en | output | 1 | Keep the scan completing this cycle |
| acq_done | output | 1 | One-cycle end-of-record pulse |
| pre_kept | output | CNT_W | Scans kept before the trigger |

## Verification
A wrong state shows up in the same cycle as a store_en that is present or missing on the next scan pulse. It also shows up as acq_active differing from the expected level, one edge after the trigger or enable change that caused it. A counter that is off by one shows up only at the end of a record, as an early or late acq_done, or as a wrong pre_kept after the trigger. For that reason, every scenario runs the record to its end and compares all four outputs on every clock.

// File: rtl/tacq_pkg.sv
package tacq_pkg;

    typedef enum logic [2:0] {
        MODE_SOFT = 3'd0,
        MODE_POST = 3'd1,
        MODE_PRE  = 3'd2,
        MODE_MID  = 3'd3,
        MODE_DLY  = 3'd4
    } trig_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREFILL,
        ST_WAIT,
        ST_DELAY,
        ST_POST
    } acq_state_e;

    // State entered when a run is armed in the given mode
    function automatic acq_state_e arm_target(input logic [2:0] m);
        case (m)
            MODE_SOFT:           return ST_POST;
            MODE_POST, MODE_DLY: return ST_WAIT;
            MODE_PRE, MODE_MID:  return ST_PREFILL;
            default:             return ST_IDLE;
        endcase
    endfunction

    function automatic logic can_rearm(input logic [2:0] m);
        return (m == MODE_POST) || (m == MODE_DLY);
    endfunction

endpackage

// File: rtl/tacq_edge.sv
module tacq_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/tacq_downcnt.sv
module tacq_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                    cnt <= '0;
        else if (load)              cnt <= load_val;
        else if (dec && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign is_zero = (cnt == '0);
    assign is_last = (cnt <= W'(1));
endmodule

// File: rtl/tacq_satcnt.sv
module tacq_satcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)              cnt <= '0;
        else if (inc && cnt < limit) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tacq_ctrl.sv
module tacq_ctrl
    import tacq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acq_en,
    input  logic [2:0]       mode,
    input  logic             retrig_en,
    input  logic [CNT_W-1:0] m_scans,
    input  logic [CNT_W-1:0] n_scans,
    input  logic [DLY_W-1:0] dly_clks,
    input  logic             ext_trig,
    input  logic             scan_done,
    output logic             acq_active,
    output logic             store_en,
    output logic             acq_done,
    output logic [CNT_W-1:0] pre_kept
);
    acq_state_e st, st_nxt;
    logic start, done_nxt;
    logic n_load, n_dec, n_last, n_zero_unused;
    logic d_load, d_dec, d_zero, d_last_unused;
    logic pre_clr, pre_inc;

    tacq_edge u_arm (.clk(clk), .rst(rst), .level(acq_en), .rise(start));

    tacq_downcnt #(.W(CNT_W)) u_ncnt (
        .clk(clk), .rst(rst), .load(n_load), .load_val(n_scans), .dec(n_dec),
        .is_zero(n_zero_unused), .is_last(n_last)
    );

    tacq_downcnt #(.W(DLY_W)) u_dcnt (
        .clk(clk), .rst(rst), .load(d_load), .load_val(dly_clks), .dec(d_dec),
        .is_zero(d_zero), .is_last(d_last_unused)
    );

    tacq_satcnt #(.W(CNT_W)) u_pre (
        .clk(clk), .rst(rst), .clr(pre_clr), .inc(pre_inc), .limit(m_scans), .cnt(pre_kept)
    );

    always_comb begin
        st_nxt   = st;
        n_load   = 1'b0;
        n_dec    = 1'b0;
        d_load   = 1'b0;
        d_dec    = 1'b0;
        pre_clr  = 1'b0;
        pre_inc  = 1'b0;
        done_nxt = 1'b0;
        if (!acq_en) begin
            st_nxt = ST_IDLE;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    pre_clr = 1'b1;
                    st_nxt  = arm_target(mode);
                    n_load  = (arm_target(mode) == ST_POST);
                end
                ST_PREFILL: begin
                    pre_inc = scan_done;
                    if (ext_trig) begin
                        if (mode == MODE_MID) begin
                            st_nxt = ST_POST;
                            n_load = 1'b1;
                        end else begin
                            st_nxt   = ST_IDLE;
                            done_nxt = 1'b1;
                        end
                    end
                end
                ST_WAIT: if (ext_trig) begin
                    if (mode == MODE_DLY) begin
                        st_nxt = ST_DELAY;
                        d_load = 1'b1;
                    end else begin
                        st_nxt = ST_POST;
                        n_load = 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (d_zero) begin
                        st_nxt = ST_POST;
                        n_load = 1'b1;
                    end else begin
                        d_dec = 1'b1;
                    end
                end
                ST_POST: if (scan_done) begin
                    n_dec = 1'b1;
                    if (n_last) begin
                        done_nxt = 1'b1;
                        st_nxt   = (retrig_en && can_rearm(mode)) ? ST_WAIT : ST_IDLE;
                    end
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            acq_done <= 1'b0;
        end else begin
            st       <= st_nxt;
            acq_done <= done_nxt;
        end
    end

    assign acq_active = (st != ST_IDLE);
    assign store_en   = scan_done && (st == ST_PREFILL || st == ST_POST);
endmodule

// File: rtl/tacq_ctrl_chk.sv
module tacq_ctrl_chk
    import tacq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       acq_en,
    input logic [2:0] mode,
    input logic       acq_active,
    input logic       store_en,
    input logic       acq_done,
    input acq_state_e st
);
    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        acq_done |=> !acq_done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acq_active |-> !store_en);

    // R2
    drop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acq_en |=> (!acq_active && !acq_done));

    // R2
    arm_start_chk: assert property (@(posedge clk) disable iff (rst)
        (acq_en && !$past(acq_en) && !acq_active && mode <= 3'd4) |=> acq_active);

    // R4
    wait_nostore_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WAIT || st == ST_DELAY) |-> !store_en);

    // R10
    delay_to_post_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == ST_DELAY && st != ST_DELAY && acq_en) |-> st == ST_POST);
endmodule

bind tacq_ctrl tacq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .acq_en(acq_en), .mode(mode),
    .acq_active(acq_active), .store_en(store_en), .acq_done(acq_done), .st(st)
);

// File: tb/test_tacq_ctrl.sv
module test_tacq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acq_en = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        retrig_en = 1'b0;
    logic [15:0] m_scans = 16'd0;
    logic [15:0] n_scans = 16'd0;
    logic [15:0] dly_clks = 16'd0;
    logic        ext_trig = 1'b0;
    logic        scan_done = 1'b0;
    logic        acq_active, store_en, acq_done;
    logic [15:0] pre_kept;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 pre-fill, 2 wait trigger, 3 delay, 4 post
    int ms = 0;
    int e_n = 0, e_d = 0, e_pre = 0;
    bit e_done = 0, m_enq = 0;
    int dones = 0;

    tacq_ctrl i_tacq_ctrl (
        .clk(clk), .rst(rst), .acq_en(acq_en), .mode(mode), .retrig_en(retrig_en),
        .m_scans(m_scans), .n_scans(n_scans), .dly_clks(dly_clks),
        .ext_trig(ext_trig), .scan_done(scan_done),
        .acq_active(acq_active), .store_en(store_en), .acq_done(acq_done),
        .pre_kept(pre_kept)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit rise;
        rise = acq_en && !m_enq;
        e_done = 0;
        if (!acq_en) ms = 0;
        else case (ms)
            0: if (rise) begin
                e_pre = 0;
                case (mode)
                    3'd0: begin ms = 4; e_n = n_scans; end
                    3'd1, 3'd4: ms = 2;
                    3'd2, 3'd3: ms = 1;
                    default: ms = 0;
                endcase
            end
            1: begin
                if (scan_done && e_pre < int'(m_scans)) e_pre++;
                if (ext_trig) begin
                    if (mode == 3'd3) begin ms = 4; e_n = n_scans; end
                    else begin ms = 0; e_done = 1; end
                end
            end
            2: if (ext_trig) begin
                if (mode == 3'd4) begin ms = 3; e_d = dly_clks; end
                else begin ms = 4; e_n = n_scans; end
            end
            3: if (e_d == 0) begin ms = 4; e_n = n_scans; end else e_d--;
            4: if (scan_done) begin
                if (e_n <= 1) begin
                    e_done = 1;
                    ms = (retrig_en && (mode == 3'd1 || mode == 3'd4)) ? 2 : 0;
                end else e_n--;
            end
            default: ms = 0;
        endcase
        m_enq = acq_en;
        if (e_done) dones++;
    endtask

    // one clock: drive at negedge, compare mid-cycle, advance model after edge
    task automatic step(input bit trig, input bit scan);
        @(negedge clk);
        ext_trig  = trig;
        scan_done = scan;
        #2;
        chk("R2 acq_active", int'(acq_active), int'(ms != 0));
        chk("R4 store_en", int'(store_en), int'(scan && (ms == 1 || ms == 4)));
        chk("R11 acq_done", int'(acq_done), int'(e_done));
        chk("R5 pre_kept", int'(pre_kept), e_pre);
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic scans(input int cnt, input int gap);
        for (int i = 0; i < cnt; i++) begin
            step(0, 1);
            for (int j = 0; j < gap; j++) step(0, 0);
        end
    endtask

    task automatic run_idle(input int cyc);
        for (int i = 0; i < cyc; i++) step(0, 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        #1;
        chk("R1 active", int'(acq_active), 0);
        chk("R1 done", int'(acq_done), 0);
        chk("R1 pre_kept", int'(pre_kept), 0);
        run_idle(2);

        // R3 software mode, n=3
        mode = 3'd0; n_scans = 16'd3; acq_en = 1'b1;
        run_idle(1);
        chk("R3 started", int'(acq_active), 1);
        dones = 0;
        scans(4, 1);
        chk("R3 one record", dones, 1);
        chk("R3 idle after", int'(acq_active), 0);
        acq_en = 1'b0; run_idle(2);

        // R3 n=0 treated as one scan
        n_scans = 16'd0; acq_en = 1'b1; dones = 0;
        scans(2, 1);
        chk("R3 zero count", dones, 1);
        acq_en = 1'b0; run_idle(2);

        // R4 post mode with scans before trigger, R10 trigger during post ignored
        mode = 3'd1; n_scans = 16'd3; acq_en = 1'b1;
        scans(3, 1);
        step(1, 1);
        step(0, 1); step(1, 0); step(1, 1); step(0, 0);
        step(0, 1); step(0, 0);
        chk("R10 finished despite extra triggers", int'(acq_active), 0);
        acq_en = 1'b0; run_idle(2);

        // R5 pre mode, m=3, five scans then trigger
        mode = 3'd2; m_scans = 16'd3; acq_en = 1'b1; dones = 0;
        run_idle(1);
        scans(5, 1);
        step(1, 0); run_idle(1);
        chk("R5 saturated pre count", int'(pre_kept), 3);
        chk("R5 done on trigger", dones, 1);
        acq_en = 1'b0; run_idle(2);

        // R6/R7 middle mode, early trigger coinciding with second scan
        mode = 3'd3; m_scans = 16'd4; n_scans = 16'd2; acq_en = 1'b1;
        run_idle(1);
        step(0, 1); step(0, 0); step(1, 1);
        chk("R7 short pre record", int'(pre_kept), 2);
        scans(3, 1);
        chk("R6 middle done", int'(acq_active), 0);
        acq_en = 1'b0; run_idle(2);
        chk("R7 pre cleared next run kept", int'(pre_kept), 2);

        // R8 delay mode d=3, scans during delay dropped; R10 trigger during delay
        mode = 3'd4; dly_clks = 16'd3; n_scans = 16'd2; acq_en = 1'b1;
        scans(2, 0);
        step(1, 0);
        step(0, 1); step(1, 1); step(0, 1); step(0, 1);
        step(0, 1); step(0, 1); step(0, 0);
        chk("R8 delay record done", int'(acq_active), 0);
        acq_en = 1'b0; run_idle(2);

        // R9 re-trigger in post mode: two records, stays active
        mode = 3'd1; retrig_en = 1'b1; n_scans = 16'd2; acq_en = 1'b1; dones = 0;
        run_idle(1);
        step(1, 0); scans(2, 1);
        chk("R9 still active", int'(acq_active), 1);
        step(1, 1); scans(3, 0);
        chk("R9 two records", dones, 2);
        // R9 re-trigger in delay mode
        mode = 3'd4; dly_clks = 16'd0;
        step(1, 0); scans(3, 0);
        chk("R9 delay rearm", int'(acq_active), 1);
        // R2 drop of enable mid-run gives no done
        step(1, 0); step(0, 1);
        acq_en = 1'b0;
        dones = 0;
        step(0, 1); step(0, 1);
        chk("R2 dropped no done", dones, 0);
        retrig_en = 1'b0;

        // R2 invalid mode never starts
        mode = 3'd6; acq_en = 1'b1;
        run_idle(3);
        chk("R2 invalid mode idle", int'(acq_active), 0);
        acq_en = 1'b0; run_idle(2);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule